// File: doc/BRIEF.md
# Slot-Based PCI Interrupt Router

This block collects the four interrupt pins of every PCI slot on a host bridge and folds them into a single interrupt request towards the CPU. Each slot and pin pair is steered onto one of the bridge's internal interrupt lines by a fixed, slot-dependent table. In the system numbering, internal line k is interrupt number 32 + k. Requests from slots that the table does not cover are not translated. Their pins are ORed per pin and leave the block on a separate pass-through output.

Two configuration vectors select the behaviour of each internal line. One bit picks edge or level operation and the other picks the level polarity. The register file that holds these vectors lives outside this block. An edge line produces a single one-cycle pulse when its routed request rises. A level line drives the CPU output while its request is high, but only when its polarity bit is 1. All line contributions are ORed, then registered. The request bit for slot s, pin n sits at index s*4+n. The slot number is a device/function number shifted right by three.

Top module: `irq_slot_router`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `cpu_irq_o` is 0 and `pass_irq_o` is 0.
- R2: Slot 5, pin n (request bit 20+n) drives internal line n mod 4.
- R3: Every pin of slot 6 drives internal line 4, and every pin of slot 7 drives internal line 5.
- R4: Slots 8 to 12, pin n, drive internal line (slot - 8 + n) + 6, so lines 6 to 13 are reachable.
- R5: Pins of any other slot reach no internal line and never move `cpu_irq_o`. Pin n of such a slot sets `pass_irq_o[n]` one cycle later, ORed over all such slots.
- R6: A line whose `edge_cfg_i` bit is 1 raises `cpu_irq_o` for exactly one cycle, in the cycle after its routed request goes from 0 to 1. Holding the request high gives no further pulse.
- R7: A line whose `edge_cfg_i` bit is 0 and whose `pol_cfg_i` bit is 1 holds `cpu_irq_o` high one cycle after each cycle in which its routed request is high.
- R8: A line whose `edge_cfg_i` bit is 0 and whose `pol_cfg_i` bit is 0 contributes nothing to `cpu_irq_o`.
- R9: `cpu_irq_o` is the OR of the contributions of all internal lines, taken one clock after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SLOTS*PINS | Interrupt pin requests, bit s*PINS+n is slot s pin n |
| edge_cfg_i | input | NUM_LINES | Per internal line: 1 = edge pulse, 0 = level |
| pol_cfg_i | input | NUM_LINES | Per internal line level polarity: 1 raises the output, 0 keeps it low |
| cpu_irq_o | output | 1 | Registered interrupt request to the CPU |
| pass_irq_o | output | PINS | Registered per-pin OR of requests from untranslated slots |

## Verification
Both outputs are due on the first rising clock edge after the inputs that cause them. An edge pulse is due in that cycle and must be gone one edge later. The bench changes requests and configuration on the falling edge and waits for the next rising edge. It compares 1 ns after that edge against a model that keeps its own copy of the previous routed line vector. Rising-edge detection is checked against that copy, so a pulse that comes one cycle late, or lasts two cycles, is reported.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

  localparam int PIN_GROUP = 4;

  // Internal line for a slot/pin pair, or -1 when the slot is not translated.
  function automatic int line_of(input int slot, input int pin);
    int dst;
    dst = -1;
    if (slot == 5)                      dst = pin % PIN_GROUP;
    else if (slot == 6)                 dst = 4;
    else if (slot == 7)                 dst = 5;
    else if (slot >= 8 && slot <= 12)   dst = (slot - 8 + pin) + 6;
    return dst;
  endfunction

endpackage

// File: rtl/irq_route_map.sv
`timescale 1ns/1ps
module irq_route_map #(
  parameter int NUM_SLOTS = 16,
  parameter int PINS      = 4,
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_SLOTS*PINS-1:0] req_i,
  output logic [NUM_LINES-1:0]      line_o,
  output logic [PINS-1:0]           pass_o
);
  import irq_route_pkg::*;

  localparam int REQ_W = NUM_SLOTS * PINS;

  // One OR tree per internal line over the sources the table steers to it.
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [REQ_W-1:0] hit;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int DST = line_of(s, p);
        assign hit[s*PINS+p] = (DST == l) ? req_i[s*PINS+p] : 1'b0;
      end
    end
    assign line_o[l] = |hit;
  end

  // Untranslated slots keep their pin number.
  for (genvar p = 0; p < PINS; p++) begin : g_pass
    logic [NUM_SLOTS-1:0] raw;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_src
      localparam int DST = line_of(s, p);
      assign raw[s] = (DST < 0) ? req_i[s*PINS+p] : 1'b0;
    end
    assign pass_o[p] = |raw;
  end

endmodule

// File: rtl/irq_line_cell.sv
`timescale 1ns/1ps
module irq_line_cell (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  output logic contrib_o
);
  logic line_q;
  logic pulse;
  logic level;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_i;
  end

  assign pulse     = edge_mode_i & line_i & ~line_q;
  assign level     = ~edge_mode_i & pol_i & line_i;
  assign contrib_o = pulse | level;

  // R6: an edge event never yields two consecutive pulse cycles
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/irq_slot_router.sv
`timescale 1ns/1ps
module irq_slot_router #(
  parameter int NUM_SLOTS = 16,
  parameter int PINS      = 4,
  parameter int NUM_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS*PINS-1:0] req_i,
  input  logic [NUM_LINES-1:0]      edge_cfg_i,
  input  logic [NUM_LINES-1:0]      pol_cfg_i,
  output logic                      cpu_irq_o,
  output logic [PINS-1:0]           pass_irq_o
);
  logic [NUM_LINES-1:0] line_vec;
  logic [PINS-1:0]      pass_vec;
  logic [NUM_LINES-1:0] contrib;

  irq_route_map #(
    .NUM_SLOTS (NUM_SLOTS),
    .PINS      (PINS),
    .NUM_LINES (NUM_LINES)
  ) u_map (
    .req_i  (req_i),
    .line_o (line_vec),
    .pass_o (pass_vec)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cell
    irq_line_cell u_cell (
      .clk         (clk),
      .rst         (rst),
      .line_i      (line_vec[l]),
      .edge_mode_i (edge_cfg_i[l]),
      .pol_i       (pol_cfg_i[l]),
      .contrib_o   (contrib[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq_o  <= 1'b0;
      pass_irq_o <= '0;
    end else begin
      cpu_irq_o  <= |contrib;
      pass_irq_o <= pass_vec;
    end
  end

  // R7: an active-high level line that is asserted forces the output next cycle
  p_level_drive_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ((line_vec & ~edge_cfg_i & pol_cfg_i) != '0)) |-> cpu_irq_o);

  // R8: with no edge line asserted and no positive level line asserted, the output stays low
  p_mute_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ((line_vec & (edge_cfg_i | pol_cfg_i)) == '0)) |-> !cpu_irq_o);

  // R5: slot 0 is untranslated, so its pin 0 appears on the pass-through pin 0
  p_pass_slot0_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_i[0]) |-> pass_irq_o[0]);

endmodule

// File: tb/sim_irq_slot_router.sv
`timescale 1ns/1ps
module sim_irq_slot_router;
  localparam int NS = 16;
  localparam int NP = 4;
  localparam int NL = 32;
  localparam int RW = NS * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] req = '0;
  logic [NL-1:0] ecfg = '0;
  logic [NL-1:0] pcfg = '0;
  logic          cpu;
  logic [NP-1:0] pass;

  int            n_vec = 0;
  int            n_bad = 0;
  bit            done = 1'b0;
  logic [NL-1:0] prev_lines = '0;

  always #2.5 clk = ~clk;

  irq_slot_router #(.NUM_SLOTS(NS), .PINS(NP), .NUM_LINES(NL)) u0 (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .edge_cfg_i (ecfg),
    .pol_cfg_i  (pcfg),
    .cpu_irq_o  (cpu),
    .pass_irq_o (pass)
  );

  function automatic int ref_dst(input int s, input int p);
    if (s == 5) return p % 4;
    if (s == 6) return 4;
    if (s == 7) return 5;
    if (s >= 8 && s <= 12) return s + p - 2;
    return -1;
  endfunction

  function automatic logic [NL-1:0] ref_lines(input logic [RW-1:0] r);
    logic [NL-1:0] v;
    v = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NP; p++) begin
        int d;
        d = ref_dst(s, p);
        if (d >= 0 && d < NL && r[s*NP+p]) v[d] = 1'b1;
      end
    return v;
  endfunction

  function automatic logic [NP-1:0] ref_pass(input logic [RW-1:0] r);
    logic [NP-1:0] v;
    v = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NP; p++)
        if (ref_dst(s, p) < 0 && r[s*NP+p]) v[p] = 1'b1;
    return v;
  endfunction

  task automatic step(input logic [RW-1:0] r, input logic [NL-1:0] e,
                      input logic [NL-1:0] pv, input string tag);
    logic [NL-1:0] lines;
    logic          exp_cpu;
    logic [NP-1:0] exp_pass;
    @(negedge clk);
    req = r; ecfg = e; pcfg = pv;
    @(posedge clk);
    #1;
    lines    = ref_lines(r);
    exp_cpu  = |((lines & ~e & pv) | (lines & ~prev_lines & e));
    exp_pass = ref_pass(r);
    prev_lines = lines;
    n_vec++;
    if (cpu !== exp_cpu || pass !== exp_pass) begin
      n_bad++;
      $display("FAIL %s: cpu=%0b pass=%h expected cpu=%0b pass=%h",
               tag, cpu, pass, exp_cpu, exp_pass);
    end
  endtask

  function automatic logic [RW-1:0] bit_at(input int i);
    logic [RW-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [NL-1:0] line_bit(input int i);
    logic [NL-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (cpu !== 1'b0 || pass !== '0) begin
      n_bad++;
      $display("FAIL R1: cpu=%0b pass=%h expected cpu=0 pass=0", cpu, pass);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: slot 5 pins onto lines 0..3
    step(bit_at(22), '0, line_bit(2), "R2 slot5 pin2 on line2");
    step(bit_at(22), '0, line_bit(3), "R2 slot5 pin2 not line3");
    step(bit_at(23), '0, line_bit(3), "R2 slot5 pin3 on line3");
    step('0, '0, '0, "R2 idle");
    // R3: slots 6 and 7
    step(bit_at(25), '0, line_bit(4), "R3 slot6 pin1 on line4");
    step(bit_at(31), '0, line_bit(5), "R3 slot7 pin3 on line5");
    step(bit_at(31), '0, line_bit(4), "R3 slot7 not line4");
    // R4: slots 8..12
    step(bit_at(32), '0, line_bit(6), "R4 slot8 pin0 on line6");
    step(bit_at(41), '0, line_bit(9), "R4 slot10 pin1 on line9");
    step(bit_at(51), '0, line_bit(13), "R4 slot12 pin3 on line13");
    step(bit_at(51), '0, line_bit(12), "R4 slot12 pin3 not line12");
    // R5: untranslated slots
    step(bit_at(9), '0, '1, "R5 slot2 pin1 passes");
    step(bit_at(55), '1, '1, "R5 slot13 pin3 passes");
    step('0, '0, '0, "R5 idle");
    // R6: edge pulse on line 4
    step(bit_at(25), line_bit(4), '0, "R6 rise pulses");
    step(bit_at(25), line_bit(4), '0, "R6 held no pulse");
    step(bit_at(25), line_bit(4), '1, "R6 held ignores polarity");
    step('0, line_bit(4), '0, "R6 fall no pulse");
    step(bit_at(24), line_bit(4), '0, "R6 second rise pulses");
    // R7 and R8: level lines
    step(bit_at(32), '0, line_bit(6), "R7 level high");
    step(bit_at(32), '0, line_bit(6), "R7 level held");
    step('0, '0, line_bit(6), "R7 level released");
    step(bit_at(32), '0, '0, "R8 polarity zero mute");
    // R9: OR across lines
    step(bit_at(32) | bit_at(22), '0, line_bit(2), "R9 mixed lines");
    step(bit_at(32) | bit_at(41), line_bit(9), '0, "R9 edge plus muted level");

    for (int i = 0; i < 3000; i++) begin
      logic [RW-1:0] r;
      r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      step(r, NL'($urandom), NL'($urandom), "R9 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule